// File: doc/BRIEF.md
# Escape-prefixed opcode byte decoder

This block sits at the front of a small instruction engine. It pulls instruction bytes one at a time from a byte-wide fetch port, addressed by its own program counter. It works out how many opcode bytes make up the instruction. A plain opcode is one byte long. An escape byte (0x0F) is followed by one more byte. A repeat-style prefix (0xF2 or 0xF3) is followed by a second byte. When that second byte is the escape, a third byte follows as well. When a sequence is complete, the block presents the collected bytes together with a class code and a length on a valid/ready output.

Not every final byte is legal. Six one-bit-per-opcode tables decide whether a final byte is accepted, one table for each class. Software fills these tables through a plain write port. If a byte is neither an escape, a prefix nor an enabled table entry, the block stops with a fault that names the byte position where the sequence broke. The fault holds until reset. The halt opcode (0xF4) is always accepted and loads the program counter with the end-of-program address given on `end_addr`.

Back-pressure rules. On the fetch port, `fetch_valid` stays high and `fetch_addr` stays unchanged until `fetch_ready` is sampled high; at that edge `fetch_data` is taken. On the result port, `op_valid` stays high and all result fields stay unchanged until `op_ready` is sampled high. A new instruction is started only by `start` while the block is idle.

Top module: `opcode_seq_decoder`

## Requirements
- R1: After reset the program counter is 1. `fetch_valid`, `op_valid` and `fault` are low, `fault_pos` is 0, and every table entry is cleared.
- R2: The block fetches only in a fetch state, with `fetch_addr` equal to the program counter. Each accepted fetch (`fetch_valid` and `fetch_ready` both high) takes the byte and adds 1 to the program counter. Without an accepted fetch or a halt, the counter keeps its value.
- R3: `start` while idle begins a fetch in the next cycle. `start` has no effect while fetching, while holding a result, or after a fault. Without `start`, an idle block stays idle.
- R4: A first byte that is not 0x0F, 0xF2, 0xF3 or 0xF4 completes a one-byte instruction if its entry in table 0 is set. The result is `op_len` 1, `op_class` 0, the byte on `op_b0`, and `op_b1`/`op_b2` zero.
- R5: A first byte of 0xF4 always completes with `op_class` 6 and `op_len` 1, regardless of the tables. On that fetch the program counter is loaded with `end_addr` instead of being incremented.
- R6: A first byte of 0x0F is followed by a second fetch. The second byte (on `op_b1`) completes with `op_class` 1 and `op_len` 2 if its entry in table 1 is set.
- R7: A first byte of 0xF2 or 0xF3 is followed by a second fetch. A second byte other than 0x0F completes with `op_len` 2 if its entry is set. The table used is table 2 for 0xF2 and table 3 for 0xF3, and `op_class` is 2 or 3 to match.
- R8: After 0xF2 or 0xF3, a second byte of 0x0F always leads to a third fetch. The third byte (on `op_b2`) completes with `op_len` 3 if its entry is set. The table used is table 4 after 0xF2 0x0F and table 5 after 0xF3 0x0F, and `op_class` is 4 or 5 to match.
- R9: A byte that breaks the sequence raises `fault` with `fault_pos` set to the position of that byte. The position is 1 for the first byte, 2 for the second byte (after 0x0F, 0xF2 or 0xF3), and 3 for the third byte. `op_valid` is never raised for a faulted sequence.
- R10: Once raised, `fault` stays high until reset. While it is high, no fetch is made, `op_valid` stays low and the program counter does not change.
- R11: While `op_valid` is high and `op_ready` is low, the result bytes, length and class stay unchanged. While `fetch_ready` is low, the program counter stays unchanged.
- R12: A cycle with `tbl_we` high sets entry `tbl_opc` of table `tbl_sel` (0 to 5) to `tbl_en`. An escape, prefix or halt byte is never looked up in the first position, and 0x0F is never looked up in the second position after a prefix. A table entry for such a byte therefore has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin decoding one instruction (idle only) |
| end_addr | input | AW | Value loaded into the program counter by halt |
| fetch_valid | output | 1 | Fetch request pending |
| fetch_ready | input | 1 | Memory accepts the fetch this cycle |
| fetch_addr | output | AW | Byte address (program counter) |
| fetch_data | input | 8 | Byte read at `fetch_addr` |
| op_valid | output | 1 | Completed opcode sequence available |
| op_ready | input | 1 | Consumer takes the result |
| op_b0 | output | 8 | First opcode byte |
| op_b1 | output | 8 | Second opcode byte, zero if unused |
| op_b2 | output | 8 | Third opcode byte, zero if unused |
| op_len | output | 2 | Number of bytes collected |
| op_class | output | 3 | Class code 0 to 6 as in R4 to R8 |
| fault | output | 1 | Sticky fault on an unrecognised sequence |
| fault_pos | output | 2 | Byte position of the fault, 0 when no fault |
| pc_out | output | AW | Current program counter |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 3 | Table to write (0 to 5) |
| tbl_opc | input | 8 | Opcode entry to write |
| tbl_en | input | 1 | Value written into the entry |

## Verification
The bench runs a stream that holds every class, and it stalls both handshakes in patterns that do not line up with the instruction boundaries. A design that advanced the counter on a stalled fetch, or that dropped a result held under back-pressure, would drift from the model at once. Halt is used to jump into target regions that fault at position 1, 2 and 3. If the bench reported the wrong position, or the counter kept going after a fault, the final position and address would differ from the expected ones. A design that checked the tables for escape or prefix bytes, or that treated 0x0F after a prefix as an opcode, would decode the enabled-escape entries as finished instructions. Clearing an entry and seeing a position-1 fault shows that a table write reaches the lookup.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_TBL   = 6;
  localparam int TBL_SEL_W = 3;

  localparam logic [BYTE_W-1:0] OPC_ESC   = 8'h0F;
  localparam logic [BYTE_W-1:0] OPC_PFX_A = 8'hF2;
  localparam logic [BYTE_W-1:0] OPC_PFX_B = 8'hF3;
  localparam logic [BYTE_W-1:0] OPC_HALT  = 8'hF4;

  // class codes double as table selectors for classes 0..5
  localparam logic [2:0] CLS_ONE    = 3'd0;
  localparam logic [2:0] CLS_ESC    = 3'd1;
  localparam logic [2:0] CLS_PA     = 3'd2;
  localparam logic [2:0] CLS_PB     = 3'd3;
  localparam logic [2:0] CLS_PA_ESC = 3'd4;
  localparam logic [2:0] CLS_PB_ESC = 3'd5;
  localparam logic [2:0] CLS_HALT   = 3'd6;

  localparam logic [1:0] FP_NONE   = 2'd0;
  localparam logic [1:0] FP_FIRST  = 2'd1;
  localparam logic [1:0] FP_SECOND = 2'd2;
  localparam logic [1:0] FP_THIRD  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET1,
    ST_GET2_ESC,
    ST_GET2_PFX,
    ST_GET3,
    ST_HOLD,
    ST_STUCK
  } dec_state_e;
endpackage

// File: rtl/opdec_table.sv
module opdec_table
  import opdec_pkg::*;
#(
  parameter int N_TBL = NUM_TBL,
  parameter int IDX_W = BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [TBL_SEL_W-1:0] wsel,
  input  logic [IDX_W-1:0]     widx,
  input  logic                 wbit,
  input  logic [TBL_SEL_W-1:0] rsel,
  input  logic [IDX_W-1:0]     ridx,
  output logic                 hit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [N_TBL-1:0] bank_hit;

  for (genvar g = 0; g < N_TBL; g++) begin : g_bank
    logic [DEPTH-1:0] bits;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bits <= '0;
      else if (we && (wsel == TBL_SEL_W'(g)))
        bits[widx] <= wbit;
    end
    assign bank_hit[g] = (rsel == TBL_SEL_W'(g)) && bits[ridx];
  end

  assign hit = |bank_hit;
endmodule

// File: rtl/opdec_pc.sv
module opdec_pc #(
  parameter int          AW       = 16,
  parameter int unsigned RESET_PC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc <= AW'(RESET_PC);
    else if (load)
      pc <= load_val;
    else if (step)
      pc <= pc + AW'(1);
  end

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (pc == $past(pc) + AW'(1)));

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(pc));

  // R5
  pc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pc == $past(load_val)));
endmodule

// File: rtl/opdec_seq.sv
module opdec_seq
  import opdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 fetch_ready,
  input  logic [BYTE_W-1:0]    fetch_data,
  input  logic                 lut_hit,
  input  logic                 op_ready,
  output logic                 fetch_valid,
  output logic                 pc_step,
  output logic                 pc_halt,
  output logic [TBL_SEL_W-1:0] lut_sel,
  output logic                 op_valid,
  output logic [BYTE_W-1:0]    op_b0,
  output logic [BYTE_W-1:0]    op_b1,
  output logic [BYTE_W-1:0]    op_b2,
  output logic [1:0]           op_len,
  output logic [2:0]           op_class,
  output logic                 fault,
  output logic [1:0]           fault_pos
);
  dec_state_e        st_q, st_d;
  logic              pfx_b_q, pfx_b_d;
  logic [BYTE_W-1:0] b0_d, b1_d, b2_d;
  logic [1:0]        len_d, fpos_d;
  logic [2:0]        cls_d;
  logic              hs;

  assign fetch_valid = (st_q == ST_GET1) || (st_q == ST_GET2_ESC) ||
                       (st_q == ST_GET2_PFX) || (st_q == ST_GET3);
  assign hs          = fetch_valid && fetch_ready;
  assign pc_step     = hs;
  assign pc_halt     = hs && (st_q == ST_GET1) && (fetch_data == OPC_HALT);
  assign op_valid    = (st_q == ST_HOLD);
  assign fault       = (st_q == ST_STUCK);

  always_comb begin
    unique case (st_q)
      ST_GET2_ESC: lut_sel = CLS_ESC;
      ST_GET2_PFX: lut_sel = pfx_b_q ? CLS_PB : CLS_PA;
      ST_GET3:     lut_sel = pfx_b_q ? CLS_PB_ESC : CLS_PA_ESC;
      default:     lut_sel = CLS_ONE;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    pfx_b_d = pfx_b_q;
    b0_d    = op_b0;
    b1_d    = op_b1;
    b2_d    = op_b2;
    len_d   = op_len;
    cls_d   = op_class;
    fpos_d  = fault_pos;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_GET1;
          b0_d  = '0;
          b1_d  = '0;
          b2_d  = '0;
          len_d = 2'd0;
          cls_d = CLS_ONE;
        end
      end
      ST_GET1: begin
        if (hs) begin
          b0_d  = fetch_data;
          len_d = 2'd1;
          if (fetch_data == OPC_HALT) begin
            cls_d = CLS_HALT;
            st_d  = ST_HOLD;
          end else if (fetch_data == OPC_ESC) begin
            st_d = ST_GET2_ESC;
          end else if ((fetch_data == OPC_PFX_A) || (fetch_data == OPC_PFX_B)) begin
            pfx_b_d = (fetch_data == OPC_PFX_B);
            st_d    = ST_GET2_PFX;
          end else if (lut_hit) begin
            cls_d = CLS_ONE;
            st_d  = ST_HOLD;
          end else begin
            fpos_d = FP_FIRST;
            st_d   = ST_STUCK;
          end
        end
      end
      ST_GET2_ESC: begin
        if (hs) begin
          b1_d  = fetch_data;
          len_d = 2'd2;
          if (lut_hit) begin
            cls_d = CLS_ESC;
            st_d  = ST_HOLD;
          end else begin
            fpos_d = FP_SECOND;
            st_d   = ST_STUCK;
          end
        end
      end
      ST_GET2_PFX: begin
        if (hs) begin
          b1_d  = fetch_data;
          len_d = 2'd2;
          if (fetch_data == OPC_ESC) begin
            st_d = ST_GET3;
          end else if (lut_hit) begin
            cls_d = pfx_b_q ? CLS_PB : CLS_PA;
            st_d  = ST_HOLD;
          end else begin
            fpos_d = FP_SECOND;
            st_d   = ST_STUCK;
          end
        end
      end
      ST_GET3: begin
        if (hs) begin
          b2_d  = fetch_data;
          len_d = 2'd3;
          if (lut_hit) begin
            cls_d = pfx_b_q ? CLS_PB_ESC : CLS_PA_ESC;
            st_d  = ST_HOLD;
          end else begin
            fpos_d = FP_THIRD;
            st_d   = ST_STUCK;
          end
        end
      end
      ST_HOLD: begin
        if (op_ready) st_d = ST_IDLE;
      end
      ST_STUCK: st_d = ST_STUCK;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      pfx_b_q   <= 1'b0;
      op_b0     <= '0;
      op_b1     <= '0;
      op_b2     <= '0;
      op_len    <= 2'd0;
      op_class  <= CLS_ONE;
      fault_pos <= FP_NONE;
    end else begin
      st_q      <= st_d;
      pfx_b_q   <= pfx_b_d;
      op_b0     <= b0_d;
      op_b1     <= b1_d;
      op_b2     <= b2_d;
      op_len    <= len_d;
      op_class  <= cls_d;
      fault_pos <= fpos_d;
    end
  end

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && !fetch_valid && !op_valid));

  // R9
  fault_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_pos != FP_NONE));

  // R11
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=>
      (op_valid && $stable({op_b0, op_b1, op_b2, op_len, op_class})));

  // R3
  idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !op_valid && !fault && !start) |=> !fetch_valid);
endmodule

// File: rtl/opcode_seq_decoder.sv
module opcode_seq_decoder
  import opdec_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int unsigned RESET_PC = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        end_addr,
  output logic                 fetch_valid,
  input  logic                 fetch_ready,
  output logic [AW-1:0]        fetch_addr,
  input  logic [BYTE_W-1:0]    fetch_data,
  output logic                 op_valid,
  input  logic                 op_ready,
  output logic [BYTE_W-1:0]    op_b0,
  output logic [BYTE_W-1:0]    op_b1,
  output logic [BYTE_W-1:0]    op_b2,
  output logic [1:0]           op_len,
  output logic [2:0]           op_class,
  output logic                 fault,
  output logic [1:0]           fault_pos,
  output logic [AW-1:0]        pc_out,
  input  logic                 tbl_we,
  input  logic [TBL_SEL_W-1:0] tbl_sel,
  input  logic [BYTE_W-1:0]    tbl_opc,
  input  logic                 tbl_en
);
  logic                 pc_step, pc_halt, lut_hit;
  logic [TBL_SEL_W-1:0] lut_sel;
  logic [AW-1:0]        pc;

  opdec_pc #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (pc_step),
    .load     (pc_halt),
    .load_val (end_addr),
    .pc       (pc)
  );

  opdec_table #(.N_TBL(NUM_TBL), .IDX_W(BYTE_W)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .wsel  (tbl_sel),
    .widx  (tbl_opc),
    .wbit  (tbl_en),
    .rsel  (lut_sel),
    .ridx  (fetch_data),
    .hit   (lut_hit)
  );

  opdec_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .fetch_ready (fetch_ready),
    .fetch_data  (fetch_data),
    .lut_hit     (lut_hit),
    .op_ready    (op_ready),
    .fetch_valid (fetch_valid),
    .pc_step     (pc_step),
    .pc_halt     (pc_halt),
    .lut_sel     (lut_sel),
    .op_valid    (op_valid),
    .op_b0       (op_b0),
    .op_b1       (op_b1),
    .op_b2       (op_b2),
    .op_len      (op_len),
    .op_class    (op_class),
    .fault       (fault),
    .fault_pos   (fault_pos)
  );

  assign fetch_addr = pc;
  assign pc_out     = pc;

  // R10
  fault_pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && $past(fault)) |-> $stable(pc_out));

  // R2
  fetch_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));
endmodule

// File: tb/sim_opcode_seq_decoder.sv
module sim_opcode_seq_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] end_addr = 16'h0;
  logic        fetch_valid, fetch_ready = 1'b0;
  logic [15:0] fetch_addr, pc_out;
  logic [7:0]  fetch_data;
  logic        op_valid, op_ready = 1'b0;
  logic [7:0]  op_b0, op_b1, op_b2;
  logic [1:0]  op_len, fault_pos;
  logic [2:0]  op_class;
  logic        fault;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_sel = 3'd0;
  logic [7:0]  tbl_opc = 8'h0;
  logic        tbl_en = 1'b0;

  logic [7:0] mem [0:255];
  int vectors = 0, miscompares = 0, cyc = 0;
  bit run_en = 1'b0, finished = 1'b0;

  // reference model state
  int          m_st = 0;  // 0 idle,1..4 fetching,5 result held,6 faulted
  logic [15:0] m_pc = 16'd1;
  bit          m_pfx_b = 1'b0;
  logic [7:0]  m_b0 = 0, m_b1 = 0, m_b2 = 0;
  int          m_len = 0, m_cls = 0, m_fpos = 0;
  bit          m_tbl [0:5][0:255];

  always #4 clk = ~clk;

  assign fetch_data = mem[fetch_addr[7:0]];

  opcode_seq_decoder #(.AW(16), .RESET_PC(1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .end_addr(end_addr),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .op_valid(op_valid), .op_ready(op_ready),
    .op_b0(op_b0), .op_b1(op_b1), .op_b2(op_b2),
    .op_len(op_len), .op_class(op_class),
    .fault(fault), .fault_pos(fault_pos), .pc_out(pc_out),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_opc(tbl_opc), .tbl_en(tbl_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit looked(input int sel, input logic [7:0] b);
    return m_tbl[sel][b];
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pc = 16'd1; m_pfx_b = 0;
      m_b0 = 0; m_b1 = 0; m_b2 = 0; m_len = 0; m_cls = 0; m_fpos = 0;
      for (int s = 0; s < 6; s++)
        for (int o = 0; o < 256; o++) m_tbl[s][o] = 1'b0;
    end else begin
      logic [7:0] d;
      bit taken;
      d = mem[m_pc[7:0]];
      taken = (m_st >= 1) && (m_st <= 4) && fetch_ready;
      case (m_st)
        0: if (start) begin
             m_st = 1; m_b0 = 0; m_b1 = 0; m_b2 = 0; m_len = 0; m_cls = 0;
           end
        1: if (taken) begin
             m_b0 = d; m_len = 1;
             m_pc = (d == 8'hF4) ? end_addr : m_pc + 16'd1;
             if (d == 8'hF4) begin m_cls = 6; m_st = 5; end
             else if (d == 8'h0F) m_st = 2;
             else if (d == 8'hF2 || d == 8'hF3) begin m_pfx_b = (d == 8'hF3); m_st = 3; end
             else if (looked(0, d)) begin m_cls = 0; m_st = 5; end
             else begin m_fpos = 1; m_st = 6; end
           end
        2: if (taken) begin
             m_b1 = d; m_len = 2; m_pc = m_pc + 16'd1;
             if (looked(1, d)) begin m_cls = 1; m_st = 5; end
             else begin m_fpos = 2; m_st = 6; end
           end
        3: if (taken) begin
             m_b1 = d; m_len = 2; m_pc = m_pc + 16'd1;
             if (d == 8'h0F) m_st = 4;
             else if (looked(m_pfx_b ? 3 : 2, d)) begin m_cls = m_pfx_b ? 3 : 2; m_st = 5; end
             else begin m_fpos = 2; m_st = 6; end
           end
        4: if (taken) begin
             m_b2 = d; m_len = 3; m_pc = m_pc + 16'd1;
             if (looked(m_pfx_b ? 5 : 4, d)) begin m_cls = m_pfx_b ? 5 : 4; m_st = 5; end
             else begin m_fpos = 3; m_st = 6; end
           end
        5: if (op_ready) m_st = 0;
        default: ;
      endcase
      if (tbl_we && tbl_sel < 6) m_tbl[tbl_sel][tbl_opc] = tbl_en;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R2 fetch_valid", fetch_valid, (m_st >= 1 && m_st <= 4));
      chk("R2 fetch_addr", fetch_addr, m_pc);
      chk("R5 pc_out", pc_out, m_pc);
      chk("R11 op_valid", op_valid, m_st == 5);
      chk("R4 op_b0", op_b0, m_b0);
      chk("R6 op_b1", op_b1, m_b1);
      chk("R8 op_b2", op_b2, m_b2);
      chk("R8 op_len", op_len, m_len);
      chk("R7 op_class", op_class, m_cls);
      chk("R10 fault", fault, m_st == 6);
      chk("R9 fault_pos", fault_pos, m_fpos);
    end
  end

  // handshake and start patterns
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      start       = run_en && (cyc % 5 == 0);
      fetch_ready = (cyc % 3 != 2);
      op_ready    = (cyc % 4 != 1);
    end
  end

  task automatic wr(input int sel, input logic [7:0] opc, input bit en);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 3'(sel); tbl_opc = opc; tbl_en = en;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic do_reset();
    run_en = 0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset pc", pc_out, 16'd1);
    chk("R1 reset fetch_valid", fetch_valid, 0);
    chk("R1 reset op_valid", op_valid, 0);
    chk("R1 reset fault", fault, 0);
    chk("R1 reset fault_pos", fault_pos, 0);
    chk("R3 idle without start", fetch_valid, 0);
  endtask

  task automatic program_tables();
    wr(0, 8'h90, 1); wr(0, 8'h01, 1);
    wr(1, 8'hAF, 1);
    wr(2, 8'h10, 1); wr(3, 8'hA4, 1);
    wr(4, 8'h58, 1); wr(5, 8'h2C, 1);
    // R12: entries for escape/prefix/halt bytes must not change decoding
    wr(0, 8'h0F, 1); wr(0, 8'hF2, 1); wr(0, 8'hF4, 0); wr(2, 8'h0F, 1);
  endtask

  task automatic run_phase(input logic [15:0] tgt, input int exp_pos,
                           input logic [15:0] exp_pc, input string tag);
    end_addr = tgt;
    do_reset();
    program_tables();
    run_en = 1;
    repeat (400) @(negedge clk);
    chk({tag, " R9 final fault_pos"}, fault_pos, exp_pos);
    chk({tag, " R10 fault held"}, fault, 1);
    chk({tag, " R5 final pc"}, pc_out, exp_pc);
    chk({tag, " R10 no fetch after fault"}, fetch_valid, 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    // main stream at address 1
    mem[1] = 8'h90;
    mem[2] = 8'h0F; mem[3] = 8'hAF;
    mem[4] = 8'hF2; mem[5] = 8'h10;
    mem[6] = 8'hF3; mem[7] = 8'hA4;
    mem[8] = 8'hF2; mem[9] = 8'h0F; mem[10] = 8'h58;
    mem[11] = 8'hF3; mem[12] = 8'h0F; mem[13] = 8'h2C;
    mem[14] = 8'h01;
    mem[15] = 8'hF4;
    // halt targets
    mem[8'h40] = 8'h0F; mem[8'h41] = 8'h33;
    mem[8'h50] = 8'hF2; mem[8'h51] = 8'h0F; mem[8'h52] = 8'h77;
    mem[8'h60] = 8'hF3; mem[8'h61] = 8'h99;
    mem[8'h70] = 8'h55;

    run_phase(16'h0040, 2, 16'h0042, "esc second");
    run_phase(16'h0050, 3, 16'h0053, "prefix third");
    run_phase(16'h0060, 2, 16'h0062, "prefix second");
    run_phase(16'h0070, 1, 16'h0071, "first byte");

    // R12: clearing an entry makes the first instruction fault at position 1
    end_addr = 16'h0040;
    do_reset();
    program_tables();
    wr(0, 8'h90, 0);
    run_en = 1;
    repeat (100) @(negedge clk);
    chk("R12 cleared entry faults", fault_pos, 1);
    chk("R12 cleared entry pc", pc_out, 16'd2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule